// File: doc/BRIEF.md
# Operand Collector Dispatch and Drain

This block connects the issue stage to two pools of operand collectors and then to the stage that follows them. One pool is scalar and one is vector. Each cycle it can take one instruction from a valid/ready input. The instruction carries a tag and a two-bit class. The block pushes the instruction into a collector of the pool that the class selects.

In the same cycle, and independently of dispatch, a round-robin arbiter looks at every collector that has a finished instruction. It pops one of them onto a single valid/ready output.

A small tag map remembers which vector collector holds each vector instruction. A writeback notification that carries a tag is steered to that collector alone. A counter records the cycles in which an offered instruction could not be placed.

The collectors, register files and read logic are outside the block. They appear only as full flags, push strobes, done valids, pop strobes and writeback strobes.

Top module: `opnd_route`

## Requirements
- R1: Class code 0 is a scalar instruction and goes to the scalar pool. Codes 1 (vector configuration), 2 (vector memory) and 3 (vector arithmetic) go to the vector pool. An instruction is never pushed into the other pool.
- R2: A dispatch pushes into the lowest-indexed collector of the selected pool whose full flag is low. Exactly one push strobe rises, and `push_tag` carries the input tag.
- R3: When every collector of the selected pool is full, `in_ready` is low and no push strobe of either pool rises.
- R4: The drain arbiter sees scalar collectors at combined indices 0..N_SC-1 and vector collectors above them. It grants the first requester at or after its pointer, wrapping around. After a taken grant g, the pointer moves to g+1 modulo the total. `out_src` is the combined index, `out_tag` is that collector's done tag, and the matching pop strobe rises.
- R5: While `out_ready` is low, no pop strobe rises and the pointer holds. `out_valid` still shows whether any collector has a done instruction.
- R6: A vector dispatch records the tag together with the collector index. If the tag is already recorded, the entry is overwritten with the new index. A writeback that hits raises only that collector's strobe and clears the entry, so a repeat writeback of the same tag raises no strobe.
- R7: A writeback whose tag has no entry raises no strobe.
- R8: A scalar dispatch removes any entry recorded for its tag.
- R9: A vector instruction whose tag is not yet recorded is held, with `in_ready` low, while the tag map has no free entry. A vector instruction whose tag is already recorded may still dispatch.
- R10: Reset clears the arbiter pointer, so the first grant goes to the lowest requester, and sets `stall_count` to zero.
- R11: `stall_count` rises by one in every cycle with `in_valid` high and `in_ready` low, and saturates at its maximum.
- R12: Dispatch and drain operate in the same cycle without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input instruction offered |
| in_ready | output | 1 | Input instruction accepted this cycle |
| in_tag | input | TAG_W | Instruction tag |
| in_cls | input | 2 | Instruction class code |
| sc_full | input | N_SC | Scalar collector input full flags |
| sc_push | output | N_SC | Scalar collector push strobes |
| vc_full | input | N_VC | Vector collector input full flags |
| vc_push | output | N_VC | Vector collector push strobes |
| push_tag | output | TAG_W | Tag delivered with a push |
| sc_done_valid | input | N_SC | Scalar collector has a finished instruction |
| sc_done_tag | input | N_SC*TAG_W | Scalar collector head tags, packed |
| sc_done_pop | output | N_SC | Scalar collector head pop strobes |
| vc_done_valid | input | N_VC | Vector collector has a finished instruction |
| vc_done_tag | input | N_VC*TAG_W | Vector collector head tags, packed |
| vc_done_pop | output | N_VC | Vector collector head pop strobes |
| out_valid | output | 1 | Output instruction available |
| out_ready | input | 1 | Downstream accepts output |
| out_tag | output | TAG_W | Output instruction tag |
| out_src | output | clog2(N_SC+N_VC) | Combined index of the granted collector |
| wb_valid | input | 1 | Writeback notification |
| wb_tag | input | TAG_W | Writeback tag |
| vc_wb_strobe | output | N_VC | Writeback forwarded to a vector collector |
| vc_wb_tag | output | TAG_W | Tag carried with the forwarded writeback |
| stall_count | output | CNT_W | Saturating count of blocked input cycles |

## Verification
The bench drives each vector class code with various full patterns. A design that decoded the class wrongly or skipped the lowest free collector would strobe the wrong push line. A design that spilled work into the other pool when one pool was full would show a push while `in_ready` is low.

The tag map is filled to capacity. The bench then offers a new vector tag, which must stall, and an already-recorded tag, which must pass and move to its new collector. A map that leaked entries, or that did not clear an entry on writeback or on a scalar dispatch of the same tag, would produce a strobe on a repeated or stale writeback.

The drain sequences check wrap-around, sparse request patterns and a held grant under back-pressure. A pointer that advanced without a pop, or that reset to a nonzero value, would show up as a wrong `out_src` order. The stall counter is pushed past its maximum to expose a wrap.

// File: rtl/opnd_route_pkg.sv
package opnd_route_pkg;

  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_SCALAR = 2'd0,
    CLS_VCFG   = 2'd1,
    CLS_VMEM   = 2'd2,
    CLS_VALU   = 2'd3
  } instr_cls_e;

  // True for every class served by the vector pool
  function automatic logic is_vector_cls(input logic [CLS_W-1:0] c);
    case (c)
      CLS_VCFG, CLS_VMEM, CLS_VALU: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/opnd_pool_pick.sv
// Lowest-index free collector selection for one pool
module opnd_pool_pick #(
  parameter int N = 2
) (
  input  logic [N-1:0] full,
  output logic [N-1:0] pick,
  output logic         any_free
);

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && !full[i]) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign any_free = ~&full;

endmodule

// File: rtl/opnd_rr_arb.sv
// Round-robin arbiter: pointer marks the first index to consider
module opnd_rr_arb #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             advance,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             any_req
);

  logic [IDX_W-1:0] ptr_q;

  function automatic logic [IDX_W-1:0] rr_first(input logic [N-1:0] r,
                                                input logic [IDX_W-1:0] p);
    logic [IDX_W-1:0] res;
    logic             found;
    res   = '0;
    found = 1'b0;
    for (int off = 0; off < N; off++) begin
      int s;
      s = int'(p) + off;
      if (s >= N) s = s - N;
      if (!found && r[s]) begin
        res   = IDX_W'(s);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [IDX_W-1:0] next_ptr(input logic [IDX_W-1:0] g);
    return (int'(g) == N - 1) ? '0 : g + 1'b1;
  endfunction

  assign any_req = |req;
  assign gnt_idx = rr_first(req, ptr_q);

  always_comb begin
    gnt = '0;
    if (any_req) gnt[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  ptr_q <= '0;
    else if (advance && any_req) ptr_q <= next_ptr(gnt_idx);
  end

endmodule

// File: rtl/opnd_tag_map.sv
// Tag to vector-collector map with one entry per in-flight vector instruction
module opnd_tag_map #(
  parameter int TAG_W = 6,
  parameter int DEPTH = 4,
  parameter int COL_W = 1,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  output logic             can_record,
  input  logic             rec_en,
  input  logic [COL_W-1:0] rec_col,
  input  logic             clr_en,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  output logic             wb_hit,
  output logic [COL_W-1:0] wb_col
);

  logic [DEPTH-1:0] ent_v;
  logic [TAG_W-1:0] ent_tag [DEPTH];
  logic [COL_W-1:0] ent_col [DEPTH];
  logic [DEPTH-1:0] in_match, wb_match;
  logic [SLOT_W-1:0] rec_slot, wb_slot;

  function automatic logic [SLOT_W-1:0] first_set(input logic [DEPTH-1:0] v);
    logic [SLOT_W-1:0] res;
    logic              found;
    res   = '0;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && v[i]) begin
        res   = SLOT_W'(i);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      in_match[i] = ent_v[i] && (ent_tag[i] == look_tag);
      wb_match[i] = ent_v[i] && (ent_tag[i] == wb_tag);
    end
  end

  assign look_hit   = |in_match;
  assign can_record = look_hit || !(&ent_v);
  assign rec_slot   = look_hit ? first_set(in_match) : first_set(~ent_v);
  assign wb_slot    = first_set(wb_match);
  assign wb_hit     = wb_valid && (|wb_match);
  assign wb_col     = ent_col[wb_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wb_hit && wb_match[i]) ent_v[i] <= 1'b0;
        if (clr_en && in_match[i]) ent_v[i] <= 1'b0;
        if (rec_en && (rec_slot == SLOT_W'(i))) ent_v[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rec_en && (rec_slot == SLOT_W'(i))) begin
        ent_tag[i] <= look_tag;
        ent_col[i] <= rec_col;
      end
    end
  end

endmodule

// File: rtl/opnd_route.sv
module opnd_route
  import opnd_route_pkg::*;
#(
  parameter int N_SC      = 2,
  parameter int N_VC      = 2,
  parameter int TAG_W     = 6,
  parameter int MAP_DEPTH = 4,
  parameter int CNT_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [TAG_W-1:0]             in_tag,
  input  logic [CLS_W-1:0]             in_cls,
  input  logic [N_SC-1:0]              sc_full,
  output logic [N_SC-1:0]              sc_push,
  input  logic [N_VC-1:0]              vc_full,
  output logic [N_VC-1:0]              vc_push,
  output logic [TAG_W-1:0]             push_tag,
  input  logic [N_SC-1:0]              sc_done_valid,
  input  logic [N_SC*TAG_W-1:0]        sc_done_tag,
  output logic [N_SC-1:0]              sc_done_pop,
  input  logic [N_VC-1:0]              vc_done_valid,
  input  logic [N_VC*TAG_W-1:0]        vc_done_tag,
  output logic [N_VC-1:0]              vc_done_pop,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [TAG_W-1:0]             out_tag,
  output logic [$clog2(N_SC+N_VC)-1:0] out_src,
  input  logic                         wb_valid,
  input  logic [TAG_W-1:0]             wb_tag,
  output logic [N_VC-1:0]              vc_wb_strobe,
  output logic [TAG_W-1:0]             vc_wb_tag,
  output logic [CNT_W-1:0]             stall_count
);

  localparam int N_ALL = N_SC + N_VC;
  localparam int SRC_W = $clog2(N_ALL);
  localparam int COL_W = (N_VC > 1) ? $clog2(N_VC) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [COL_W-1:0] onehot_to_col(input logic [N_VC-1:0] oh);
    logic [COL_W-1:0] res;
    res = '0;
    for (int i = 0; i < N_VC; i++) if (oh[i]) res = COL_W'(i);
    return res;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  // Named internal events
  logic             want_vec;
  logic [N_SC-1:0]  sc_pick;
  logic [N_VC-1:0]  vc_pick;
  logic             sc_any_free, vc_any_free;
  logic             map_ok, map_hit;
  logic             disp_fire, stall_evt, drain_fire;
  logic             wb_hit;
  logic [COL_W-1:0] wb_col;
  logic [N_ALL-1:0] drain_req, drain_gnt;
  logic [SRC_W-1:0] gnt_idx;
  logic             any_done;

  // Dispatch side
  assign want_vec = is_vector_cls(in_cls);

  opnd_pool_pick #(.N(N_SC)) u_sc_pick (
    .full(sc_full), .pick(sc_pick), .any_free(sc_any_free)
  );

  opnd_pool_pick #(.N(N_VC)) u_vc_pick (
    .full(vc_full), .pick(vc_pick), .any_free(vc_any_free)
  );

  assign in_ready  = want_vec ? (vc_any_free && map_ok) : sc_any_free;
  assign disp_fire = in_valid && in_ready;
  assign stall_evt = in_valid && !in_ready;
  assign sc_push   = (disp_fire && !want_vec) ? sc_pick : '0;
  assign vc_push   = (disp_fire &&  want_vec) ? vc_pick : '0;
  assign push_tag  = in_tag;

  opnd_tag_map #(.TAG_W(TAG_W), .DEPTH(MAP_DEPTH), .COL_W(COL_W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_tag  (in_tag),
    .look_hit  (map_hit),
    .can_record(map_ok),
    .rec_en    (disp_fire && want_vec),
    .rec_col   (onehot_to_col(vc_pick)),
    .clr_en    (disp_fire && !want_vec),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag),
    .wb_hit    (wb_hit),
    .wb_col    (wb_col)
  );

  // Writeback steering
  always_comb begin
    vc_wb_strobe = '0;
    if (wb_hit) vc_wb_strobe[wb_col] = 1'b1;
  end
  assign vc_wb_tag = wb_tag;

  // Drain side
  assign drain_req = {vc_done_valid, sc_done_valid};

  opnd_rr_arb #(.N(N_ALL)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (drain_req),
    .advance(out_ready),
    .gnt    (drain_gnt),
    .gnt_idx(gnt_idx),
    .any_req(any_done)
  );

  assign out_valid   = any_done;
  assign drain_fire  = any_done && out_ready;
  assign out_src     = gnt_idx;
  assign sc_done_pop = out_ready ? drain_gnt[N_SC-1:0]     : '0;
  assign vc_done_pop = out_ready ? drain_gnt[N_ALL-1:N_SC] : '0;

  always_comb begin
    out_tag = '0;
    for (int i = 0; i < N_SC; i++)
      if (drain_gnt[i]) out_tag = sc_done_tag[i*TAG_W +: TAG_W];
    for (int j = 0; j < N_VC; j++)
      if (drain_gnt[N_SC+j]) out_tag = vc_done_tag[j*TAG_W +: TAG_W];
  end

  // Blocked-input counter
  always_ff @(posedge clk) begin
    if (!rst_n)         stall_count <= '0;
    else if (stall_evt) stall_count <= sat_inc(stall_count);
  end

endmodule

// File: rtl/opnd_route_sva.sv
module opnd_route_sva #(
  parameter int N_SC  = 2,
  parameter int N_VC  = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [N_SC-1:0]  sc_full,
  input logic [N_SC-1:0]  sc_push,
  input logic [N_VC-1:0]  vc_full,
  input logic [N_VC-1:0]  vc_push,
  input logic             want_vec,
  input logic             map_ok,
  input logic             map_hit,
  input logic [N_SC-1:0]  sc_done_pop,
  input logic [N_VC-1:0]  vc_done_pop,
  input logic             out_valid,
  input logic             out_ready,
  input logic [N_VC-1:0]  vc_wb_strobe,
  input logic             wb_valid,
  input logic [CNT_W-1:0] stall_count
);

  a_r1_vector_pool: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && want_vec) |-> (vc_push != '0 && sc_push == '0));

  a_r1_scalar_pool: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !want_vec) |-> (sc_push != '0 && vc_push == '0));

  a_r2_one_push: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sc_push, vc_push}));

  a_r2_never_full: assert property (@(posedge clk) disable iff (!rst_n)
    ((sc_push & sc_full) == '0) && ((vc_push & vc_full) == '0));

  a_r3_blocked_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (sc_push == '0 && vc_push == '0));

  a_r4_one_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sc_done_pop, vc_done_pop}));

  a_r4_pop_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> ({sc_done_pop, vc_done_pop} != '0));

  a_r5_hold_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> ({sc_done_pop, vc_done_pop} == '0));

  a_r6_wb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vc_wb_strobe));

  a_r7_wb_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |-> (vc_wb_strobe == '0));

  a_r9_map_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && want_vec && !map_ok) |-> !in_ready);

  a_r9_hit_implies_room: assert property (@(posedge clk) disable iff (!rst_n)
    map_hit |-> map_ok);

  a_r11_stall_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && stall_count != '1) |=> (stall_count == $past(stall_count) + 1'b1));

  a_r11_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !in_ready) |=> $stable(stall_count));

endmodule

bind opnd_route opnd_route_sva #(.N_SC(N_SC), .N_VC(N_VC), .CNT_W(CNT_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .sc_full     (sc_full),
  .sc_push     (sc_push),
  .vc_full     (vc_full),
  .vc_push     (vc_push),
  .want_vec    (want_vec),
  .map_ok      (map_ok),
  .map_hit     (map_hit),
  .sc_done_pop (sc_done_pop),
  .vc_done_pop (vc_done_pop),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .vc_wb_strobe(vc_wb_strobe),
  .wb_valid    (wb_valid),
  .stall_count (stall_count)
);

// File: tb/opnd_route_test.sv
module opnd_route_test;

  localparam int TAG_W = 6;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [TAG_W-1:0] in_tag = '0;
  logic [1:0]       in_cls = '0;
  logic [1:0]       sc_full = '0, sc_push;
  logic [1:0]       vc_full = '0, vc_push;
  logic [TAG_W-1:0] push_tag;
  logic [1:0]       sc_done_valid = '0, sc_done_pop;
  logic [1:0]       vc_done_valid = '0, vc_done_pop;
  logic [2*TAG_W-1:0] sc_done_tag = {6'd11, 6'd10};
  logic [2*TAG_W-1:0] vc_done_tag = {6'd13, 6'd12};
  logic             out_valid, out_ready = 1'b0;
  logic [TAG_W-1:0] out_tag;
  logic [1:0]       out_src;
  logic             wb_valid = 1'b0;
  logic [TAG_W-1:0] wb_tag = '0;
  logic [1:0]       vc_wb_strobe;
  logic [TAG_W-1:0] vc_wb_tag;
  logic [CNT_W-1:0] stall_count;

  int checks = 0;
  int errors = 0;
  int exp_stall = 0;
  int model_ptr = 0;

  always #2.5 clk = ~clk;

  opnd_route #(.N_SC(2), .N_VC(2), .TAG_W(TAG_W), .MAP_DEPTH(4), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag), .in_cls(in_cls),
    .sc_full(sc_full), .sc_push(sc_push), .vc_full(vc_full), .vc_push(vc_push),
    .push_tag(push_tag),
    .sc_done_valid(sc_done_valid), .sc_done_tag(sc_done_tag), .sc_done_pop(sc_done_pop),
    .vc_done_valid(vc_done_valid), .vc_done_tag(vc_done_tag), .vc_done_pop(vc_done_pop),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag), .out_src(out_src),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .vc_wb_strobe(vc_wb_strobe), .vc_wb_tag(vc_wb_tag),
    .stall_count(stall_count)
  );

  task automatic check(input string rid, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rid, what, act, exp);
    end
  endtask

  function automatic int bump(input int v);
    return (v >= 15) ? 15 : v + 1;
  endfunction

  // One dispatch attempt lasting a single cycle
  task automatic do_disp(input string rid, input int cls, input int tag,
                         input int scf, input int vcf,
                         input int exp_rdy, input int exp_sc, input int exp_vc);
    @(negedge clk);
    in_valid = 1'b1; in_cls = 2'(cls); in_tag = TAG_W'(tag);
    sc_full = 2'(scf); vc_full = 2'(vcf);
    #1;
    check(rid, "in_ready", int'(in_ready), exp_rdy);
    check(rid, "sc_push", int'(sc_push), exp_sc);
    check(rid, "vc_push", int'(vc_push), exp_vc);
    if (exp_rdy != 0) check(rid, "push_tag", int'(push_tag), tag);
    if (exp_rdy == 0) exp_stall = bump(exp_stall);
    @(posedge clk);
    #1 in_valid = 1'b0; sc_full = '0; vc_full = '0;
  endtask

  task automatic do_wb(input string rid, input int tag, input int exp_strobe);
    @(negedge clk);
    wb_valid = 1'b1; wb_tag = TAG_W'(tag);
    #1;
    check(rid, "vc_wb_strobe", int'(vc_wb_strobe), exp_strobe);
    if (exp_strobe != 0) check(rid, "vc_wb_tag", int'(vc_wb_tag), tag);
    @(posedge clk);
    #1 wb_valid = 1'b0;
  endtask

  task automatic check_stall(input string rid);
    @(negedge clk);
    check(rid, "stall_count", int'(stall_count), exp_stall);
  endtask

  function automatic int model_pick(input int req);
    for (int off = 0; off < 4; off++) begin
      int s;
      s = (model_ptr + off) % 4;
      if (req[s]) return s;
    end
    return -1;
  endfunction

  // Drain run: req bits 0..1 scalar, 2..3 vector
  task automatic arb_run(input string rid, input int req, input int rdy, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      int g;
      @(negedge clk);
      sc_done_valid = 2'(req & 3); vc_done_valid = 2'((req >> 2) & 3);
      out_ready = rdy[0];
      #1;
      g = model_pick(req);
      check(rid, "out_valid", int'(out_valid), (req != 0) ? 1 : 0);
      if (g >= 0) begin
        check(rid, "out_src", int'(out_src), g);
        check(rid, "out_tag", int'(out_tag), 10 + g);
        check(rid, "pops", int'({vc_done_pop, sc_done_pop}), rdy != 0 ? (1 << g) : 0);
        if (rdy != 0) model_ptr = (g + 1) % 4;
      end
      @(posedge clk);
    end
    #1 sc_done_valid = '0; vc_done_valid = '0; out_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10", "stall_count after reset", int'(stall_count), 0);
    check("R10", "out_valid idle", int'(out_valid), 0);
    check("R2", "no push idle", int'({sc_push, vc_push}), 0);
  endtask

  task automatic t_route();
    do_disp("R1", 0, 1, 0, 0, 1, 1, 0);
    do_disp("R1", 1, 2, 0, 0, 1, 0, 1);   // map 2->0
    do_disp("R1", 2, 3, 0, 1, 1, 0, 2);   // map 3->1, R2 skip full
    do_disp("R1", 3, 4, 0, 1, 1, 0, 2);   // map 4->1
    do_disp("R2", 0, 9, 1, 0, 1, 2, 0);
  endtask

  task automatic t_pool_full();
    do_disp("R3", 0, 10, 3, 0, 0, 0, 0);
    do_disp("R3", 3, 11, 0, 3, 0, 0, 0);
    check_stall("R11");
  endtask

  task automatic t_map();
    do_disp("R9", 1, 5, 0, 0, 1, 0, 1);   // map full: 2,3,4,5
    do_disp("R9", 1, 6, 0, 0, 0, 0, 0);   // new tag held
    do_disp("R9", 1, 5, 0, 1, 1, 0, 2);   // known tag, now 5->1
    check_stall("R11");
    do_wb("R6", 5, 2);
    do_wb("R6", 5, 0);
    do_wb("R7", 7, 0);
    do_wb("R6", 2, 1);
    do_disp("R8", 0, 3, 0, 0, 1, 1, 0);   // scalar clears tag 3
    do_wb("R8", 3, 0);
    do_wb("R6", 4, 2);
  endtask

  task automatic t_saturate();
    @(negedge clk);
    in_valid = 1'b1; in_cls = 2'd0; sc_full = 2'b11;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk);
      exp_stall = bump(exp_stall);
    end
    #1 in_valid = 1'b0; sc_full = '0;
    check_stall("R11");
  endtask

  task automatic t_arb();
    arb_run("R10", 15, 1, 1);   // first grant after reset is index 0
    arb_run("R4", 15, 1, 5);
    arb_run("R4", 10, 1, 3);
    arb_run("R5", 5, 0, 3);
    arb_run("R5", 5, 1, 2);
    arb_run("R4", 8, 1, 1);
  endtask

  task automatic t_concurrent();
    int g;
    @(negedge clk);
    in_valid = 1'b1; in_cls = 2'd3; in_tag = 6'd20; vc_full = 2'b01;
    sc_done_valid = 2'b10; vc_done_valid = 2'b01; out_ready = 1'b1;
    #1;
    g = model_pick(6);
    check("R12", "vc_push with drain", int'(vc_push), 2);
    check("R12", "in_ready with drain", int'(in_ready), 1);
    check("R12", "pop with dispatch", int'({vc_done_pop, sc_done_pop}), 1 << g);
    model_ptr = (g + 1) % 4;
    @(posedge clk);
    #1 in_valid = 1'b0; vc_full = '0; sc_done_valid = '0; vc_done_valid = '0; out_ready = 1'b0;
    do_wb("R12", 20, 2);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_arb();
    t_route();
    t_pool_full();
    t_map();
    t_saturate();
    t_concurrent();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule